// File: doc/BRIEF.md
# Eight-Window Asynchronous Peripheral Bus Controller

This controller lets an internal master reach slow external parts such as SRAM, flash and simple peripheral chips over a 16-bit asynchronous bus with 24 address lines. The controller runs on a supplied interface clock of up to 66 MHz. The external bus has eight chip-select lines. Each line has its own configuration word. That word enables the line, places an aligned address window between 512 bytes and 16 Mbytes, and chooses the strobe style. It also chooses whether the low address bits share the data pins, and how long each part of the access lasts.

An access moves through five phases in a fixed order: address, setup, strobe, hold and recovery. Each phase lasts its programmed count plus one interface clock. The master presents a request and holds it. The controller raises a one-cycle ready once recovery ends, and gives back the read data or an error flag in that same cycle. A request that falls in no enabled window ends at once with the error flag set, and nothing on the external bus moves. The configuration words come in as a static input vector that is held elsewhere in the chip.

Top module: `exbus_ctrl`

## Requirements
- R1: Chip select i takes its configuration from `cfg_flat[42*i+41:42*i]`. The fields are:
  - bit 0: enable.
  - bit 1: style, where 1 selects R/W with a data strobe and 0 selects separate read and write strobes.
  - bit 2: shared address/data pins.
  - bits 6:3: size code.
  - bits 10:7: address phase count.
  - bits 14:11: setup phase count.
  - bits 18:15: strobe phase count.
  - bits 22:19: hold phase count.
  - bits 26:23: recovery phase count.
  - bits 41:27: window base, which supplies address bits 23:9.

  A chip select whose enable bit is 0 never matches.
- R2: The window of chip select i covers `512 << size` bytes starting at its base; size code 15 covers the whole 16 Mbyte space. A request that matches no enabled window gets ready and `rsp_err` high in the first cycle after acceptance. During such a request no chip select or strobe is asserted.
- R3: When windows overlap, the lowest-numbered matching chip select serves the access.
- R4: A matched access passes through address, setup, strobe, hold and recovery in that order, and each phase lasts its count + 1 clocks. Ready is sampled high Σ(count+1)+1 cycles after the cycle in which the request was accepted. The strobe first appears count_addr + count_setup + 3 cycles after acceptance.
- R5: Exactly the selected `ext_cs_n` bit is low throughout the address, setup, strobe and hold phases, and it is high during recovery. During the same span, `ext_addr` carries the request address and `ext_be_n` carries the inverted byte enables.
- R6: In separate-strobe style, `ext_rd_n` (on reads) or `ext_wr_n` (on writes) is low for exactly the strobe phase. `ext_ds_n` and `ext_rw` stay high.
- R7: In R/W style, `ext_rw` is 0 for writes and 1 for reads, and it holds that level for the whole chip-select span. `ext_ds_n` is low for exactly the strobe phase, and `ext_rd_n` and `ext_wr_n` stay high.
- R8: In shared-pin mode, `ext_ale` is high for exactly the address phase while `ext_data_o` drives address bits 15:0 with `ext_data_oe` high. In separate-pin mode, `ext_ale` stays low.
- R9: Write data appears on `ext_data_o` with `ext_data_oe` high only in the strobe phase. `ext_data_oe` is low in every other phase except the shared-pin address phase.
- R10: Read data is captured from `ext_data_i` on the last clock of the strobe phase and is presented on `rsp_rdata` together with ready.
- R11: `req_ready` is high for one cycle per request. A request still held during that cycle is not accepted a second time.
- R12: After reset, all chip selects and strobes are high, `ext_rw` is high, `ext_ale`, `ext_data_oe`, `req_ready` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flat | input | NCS*42 | Per-chip-select configuration words |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| req_ready | output | 1 | One-cycle completion |
| rsp_rdata | output | 16 | Captured read data |
| rsp_err | output | 1 | No window matched |
| ext_cs_n | output | NCS | Active-low chip selects |
| ext_addr | output | 24 | External address lines |
| ext_be_n | output | 2 | Active-low byte enables |
| ext_data_o | output | 16 | Data/address driven out |
| ext_data_oe | output | 1 | Drive enable for the data pins |
| ext_data_i | input | 16 | Data pins as received |
| ext_ale | output | 1 | Address latch strobe (shared-pin mode) |
| ext_rd_n | output | 1 | Read strobe, separate-strobe style |
| ext_wr_n | output | 1 | Write strobe, separate-strobe style |
| ext_rw | output | 1 | Read/not-write level, R/W style |
| ext_ds_n | output | 1 | Data strobe, R/W style |

## Verification
Errors in the phase counter or in the loaded phase lengths appear at the ports within one access. They move the first strobe cycle, change the number of strobe cycles, or move the ready cycle, and the bench checks each of these against counts it computes itself. A wrong selected index or a wrong latched style appears on the first address-phase cycle as the wrong `ext_cs_n` bit or the wrong strobe pin. Wrong address routing in shared-pin mode, or a capture taken outside the strobe, changes the read data returned with ready. The external device model answers only while a valid read strobe is active, so such a fault shows in that data.

// File: rtl/exbus_pkg.sv
package exbus_pkg;

  localparam int AW   = 24;   // external address lines
  localparam int DW   = 16;   // external data width
  localparam int BEW  = DW / 8;
  localparam int PHW  = 4;    // bits per phase count
  localparam int NPH  = 5;    // phases per access
  localparam int BLSB = 9;    // smallest window is 2**BLSB bytes
  localparam int SZW  = 4;    // size code width

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;

  typedef struct packed {
    logic [AW-BLSB-1:0] base;
    logic [PHW-1:0]     t_recov;
    logic [PHW-1:0]     t_hold;
    logic [PHW-1:0]     t_strb;
    logic [PHW-1:0]     t_setup;
    logic [PHW-1:0]     t_addr;
    logic [SZW-1:0]     size;
    logic               mux;
    logic               moto;
    logic               en;
  } cs_cfg_t;

  localparam int CFGW = $bits(cs_cfg_t);

  typedef struct packed {
    logic           wr;
    logic           moto;
    logic           mux;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  wdata;
    logic [BEW-1:0] be;
  } acc_t;

endpackage

// File: rtl/exbus_decode.sv
module exbus_decode
  import exbus_pkg::*;
#(
  parameter int NCS = 8,
  parameter int CSW = 3
) (
  input  logic [AW-1:0]            addr,
  input  cs_cfg_t                  cfg [NCS],
  output logic                     hit,
  output logic [CSW-1:0]           sel,
  output logic                     sel_moto,
  output logic                     sel_mux,
  output logic [NPH-1:0][PHW-1:0]  sel_len
);

  logic [NCS-1:0] match;

  for (genvar i = 0; i < NCS; i++) begin : g_win
    logic [AW-1:0] keep;
    logic [AW-1:0] base_full;
    assign keep      = {AW{1'b1}} << (BLSB + 32'(cfg[i].size));
    assign base_full = {cfg[i].base, {BLSB{1'b0}}};
    assign match[i]  = cfg[i].en && (((addr ^ base_full) & keep) == '0);
  end

  always_comb begin
    sel = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (match[i]) sel = CSW'(i);
    end
  end

  assign hit      = |match;
  assign sel_moto = cfg[sel].moto;
  assign sel_mux  = cfg[sel].mux;
  assign sel_len  = {cfg[sel].t_recov, cfg[sel].t_hold, cfg[sel].t_strb,
                     cfg[sel].t_setup, cfg[sel].t_addr};

endmodule

// File: rtl/exbus_seq.sv
module exbus_seq
  import exbus_pkg::*;
#(
  parameter int CSW = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic [BEW-1:0]           req_be,
  input  logic                     hit,
  input  logic [CSW-1:0]           hit_sel,
  input  logic                     hit_moto,
  input  logic                     hit_mux,
  input  logic [NPH-1:0][PHW-1:0]  hit_len,
  output phase_e                   st_d,
  output acc_t                     acc_d,
  output logic [CSW-1:0]           cs_d,
  output logic                     cap,
  output logic                     req_ready,
  output logic                     rsp_err
);

  phase_e                   st_q;
  logic [PHW-1:0]           cnt_q, cnt_d;
  logic [NPH-1:0][PHW-1:0]  len_q, len_d;
  acc_t                     acc_q;
  logic [CSW-1:0]           cs_q;
  logic                     rdy_d, err_d;
  logic [2:0]               stv;

  assign stv = st_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    len_d = len_q;
    acc_d = acc_q;
    cs_d  = cs_q;
    rdy_d = 1'b0;
    err_d = 1'b0;
    if (st_q == PH_IDLE) begin
      if (req_valid && !req_ready) begin
        if (hit) begin
          st_d        = PH_ADDR;
          len_d       = hit_len;
          cnt_d       = hit_len[0];
          cs_d        = hit_sel;
          acc_d.wr    = req_write;
          acc_d.moto  = hit_moto;
          acc_d.mux   = hit_mux;
          acc_d.addr  = req_addr;
          acc_d.wdata = req_wdata;
          acc_d.be    = req_be;
        end else begin
          rdy_d = 1'b1;
          err_d = 1'b1;
        end
      end
    end else if (cnt_q == '0) begin
      if (st_q == PH_RECOV) begin
        st_d  = PH_IDLE;
        rdy_d = 1'b1;
      end else begin
        st_d  = phase_e'(stv + 3'd1);
        cnt_d = len_q[stv];
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cap = (st_q == PH_STRB) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PH_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      acc_q     <= '0;
      cs_q      <= '0;
      req_ready <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      len_q     <= len_d;
      acc_q     <= acc_d;
      cs_q      <= cs_d;
      req_ready <= rdy_d;
      rsp_err   <= err_d;
    end
  end

endmodule

// File: rtl/exbus_pins.sv
module exbus_pins
  import exbus_pkg::*;
#(
  parameter int NCS = 8,
  parameter int CSW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_e          st_d,
  input  acc_t            acc_d,
  input  logic [CSW-1:0]  cs_d,
  input  logic            cap,
  input  logic [DW-1:0]   ext_data_i,
  output logic [NCS-1:0]  ext_cs_n,
  output logic [AW-1:0]   ext_addr,
  output logic [BEW-1:0]  ext_be_n,
  output logic [DW-1:0]   ext_data_o,
  output logic            ext_data_oe,
  output logic            ext_ale,
  output logic            ext_rd_n,
  output logic            ext_wr_n,
  output logic            ext_rw,
  output logic            ext_ds_n,
  output logic [DW-1:0]   rdata_q
);

  logic act, strb, aph;

  assign act  = (st_d == PH_ADDR) || (st_d == PH_SETUP) ||
                (st_d == PH_STRB) || (st_d == PH_HOLD);
  assign strb = (st_d == PH_STRB);
  assign aph  = (st_d == PH_ADDR);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) ext_cs_n[g] <= 1'b1;
      else     ext_cs_n[g] <= !(act && (cs_d == CSW'(g)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr    <= '0;
      ext_be_n    <= '1;
      ext_data_o  <= '0;
      ext_data_oe <= 1'b0;
      ext_ale     <= 1'b0;
      ext_rd_n    <= 1'b1;
      ext_wr_n    <= 1'b1;
      ext_rw      <= 1'b1;
      ext_ds_n    <= 1'b1;
      rdata_q     <= '0;
    end else begin
      ext_addr <= act ? acc_d.addr : '0;
      ext_be_n <= act ? ~acc_d.be : '1;
      ext_rd_n <= !(strb && !acc_d.moto && !acc_d.wr);
      ext_wr_n <= !(strb && !acc_d.moto && acc_d.wr);
      ext_ds_n <= !(strb && acc_d.moto);
      ext_rw   <= !(act && acc_d.moto && acc_d.wr);
      ext_ale  <= aph && acc_d.mux;
      if (aph && acc_d.mux) begin
        ext_data_o  <= acc_d.addr[DW-1:0];
        ext_data_oe <= 1'b1;
      end else if (strb && acc_d.wr) begin
        ext_data_o  <= acc_d.wdata;
        ext_data_oe <= 1'b1;
      end else begin
        ext_data_o  <= '0;
        ext_data_oe <= 1'b0;
      end
      if (cap) rdata_q <= ext_data_i;
    end
  end

endmodule

// File: rtl/exbus_ctrl.sv
module exbus_ctrl
  import exbus_pkg::*;
#(
  parameter int NCS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCS*CFGW-1:0]  cfg_flat,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [BEW-1:0]       req_be,
  output logic                 req_ready,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_err,
  output logic [NCS-1:0]       ext_cs_n,
  output logic [AW-1:0]        ext_addr,
  output logic [BEW-1:0]       ext_be_n,
  output logic [DW-1:0]        ext_data_o,
  output logic                 ext_data_oe,
  input  logic [DW-1:0]        ext_data_i,
  output logic                 ext_ale,
  output logic                 ext_rd_n,
  output logic                 ext_wr_n,
  output logic                 ext_rw,
  output logic                 ext_ds_n
);

  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

  cs_cfg_t                  cfg_a [NCS];
  logic                     hit, hit_moto, hit_mux, cap;
  logic [CSW-1:0]           hit_sel, cs_d;
  logic [NPH-1:0][PHW-1:0]  hit_len;
  phase_e                   st_d;
  acc_t                     acc_d;

  for (genvar i = 0; i < NCS; i++) begin : g_cfg
    assign cfg_a[i] = cfg_flat[i*CFGW +: CFGW];
  end

  exbus_decode #(.NCS(NCS), .CSW(CSW)) u_dec (
    .addr     (req_addr),
    .cfg      (cfg_a),
    .hit      (hit),
    .sel      (hit_sel),
    .sel_moto (hit_moto),
    .sel_mux  (hit_mux),
    .sel_len  (hit_len)
  );

  exbus_seq #(.CSW(CSW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .hit       (hit),
    .hit_sel   (hit_sel),
    .hit_moto  (hit_moto),
    .hit_mux   (hit_mux),
    .hit_len   (hit_len),
    .st_d      (st_d),
    .acc_d     (acc_d),
    .cs_d      (cs_d),
    .cap       (cap),
    .req_ready (req_ready),
    .rsp_err   (rsp_err)
  );

  exbus_pins #(.NCS(NCS), .CSW(CSW)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .st_d        (st_d),
    .acc_d       (acc_d),
    .cs_d        (cs_d),
    .cap         (cap),
    .ext_data_i  (ext_data_i),
    .ext_cs_n    (ext_cs_n),
    .ext_addr    (ext_addr),
    .ext_be_n    (ext_be_n),
    .ext_data_o  (ext_data_o),
    .ext_data_oe (ext_data_oe),
    .ext_ale     (ext_ale),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .ext_rw      (ext_rw),
    .ext_ds_n    (ext_ds_n),
    .rdata_q     (rsp_rdata)
  );

endmodule

// File: rtl/exbus_ctrl_chk.sv
module exbus_ctrl_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           req_ready,
  input logic           rsp_err,
  input logic [NCS-1:0] ext_cs_n,
  input logic           ext_data_oe,
  input logic           ext_ale,
  input logic           ext_rd_n,
  input logic           ext_wr_n,
  input logic           ext_rw,
  input logic           ext_ds_n
);

  logic cs_act;
  assign cs_act = ~&ext_cs_n;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $countones(~ext_cs_n) <= 1); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!ext_rd_n || !ext_wr_n || !ext_ds_n) |-> cs_act); // R5
  AST_RW_HELD: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act)) |-> $stable(ext_rw)); // R7
  AST_STYLE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !((!ext_rd_n || !ext_wr_n) && !ext_ds_n)); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n)); // R6
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ext_ale |-> (cs_act && ext_rd_n && ext_wr_n && ext_ds_n && ext_data_oe)); // R8
  AST_OE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> cs_act); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (req_ready && !cs_act)); // R2

endmodule

bind exbus_ctrl exbus_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .rsp_err     (rsp_err),
  .ext_cs_n    (ext_cs_n),
  .ext_data_oe (ext_data_oe),
  .ext_ale     (ext_ale),
  .ext_rd_n    (ext_rd_n),
  .ext_wr_n    (ext_wr_n),
  .ext_rw      (ext_rw),
  .ext_ds_n    (ext_ds_n)
);

// File: tb/exbus_ctrl_tb.sv
module exbus_ctrl_tb;
  import exbus_pkg::*;

  localparam int NCS = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst = 1'b1;
  logic [NCS*42-1:0]   cfg_flat;
  logic                req_valid = 1'b0, req_write = 1'b0;
  logic [23:0]         req_addr = '0;
  logic [15:0]         req_wdata = '0;
  logic [1:0]          req_be = 2'b11;
  logic                req_ready, rsp_err;
  logic [15:0]         rsp_rdata;
  logic [NCS-1:0]      ext_cs_n;
  logic [23:0]         ext_addr;
  logic [1:0]          ext_be_n;
  logic [15:0]         ext_data_o, ext_data_i;
  logic                ext_data_oe, ext_ale, ext_rd_n, ext_wr_n, ext_rw, ext_ds_n;

  int n_run = 0, n_fail = 0;

  // per chip select setup: enable, R/W style, shared pins, size, base, phase counts
  int b_en[NCS], b_moto[NCS], b_mux[NCS], b_size[NCS], b_base[NCS];
  int tp[NCS][5];

  function automatic logic [15:0] dev_fn(logic [23:0] a);
    return a[15:0] ^ {a[23:16], 8'h5A};
  endfunction

  function automatic logic [41:0] pack_cfg(int i);
    logic [41:0] v;
    logic [23:0] b;
    v = '0;
    b = 24'(b_base[i]);
    v[0]     = b_en[i][0];
    v[1]     = b_moto[i][0];
    v[2]     = b_mux[i][0];
    v[6:3]   = 4'(b_size[i]);
    v[10:7]  = 4'(tp[i][0]);
    v[14:11] = 4'(tp[i][1]);
    v[18:15] = 4'(tp[i][2]);
    v[22:19] = 4'(tp[i][3]);
    v[26:23] = 4'(tp[i][4]);
    v[41:27] = b[23:9];
    return v;
  endfunction

  function automatic int exp_cs(logic [23:0] a);
    for (int i = 0; i < NCS; i++) begin
      if (b_en[i] != 0 && ((int'(a) >> (9 + b_size[i])) == (b_base[i] >> (9 + b_size[i]))))
        return i;
    end
    return -1;
  endfunction

  // external device model
  bit          cur_mux = 1'b0;
  logic [15:0] mux_lo = '0;
  logic [23:0] dev_addr;
  logic        rd_act, wr_act;
  logic [23:0] wr_seen_addr = '0;
  logic [15:0] wr_seen_data = '0;

  assign dev_addr   = cur_mux ? {ext_addr[23:16], mux_lo} : ext_addr;
  assign rd_act     = !ext_rd_n || (!ext_ds_n && ext_rw);
  assign wr_act     = !ext_wr_n || (!ext_ds_n && !ext_rw);
  assign ext_data_i = rd_act ? dev_fn(dev_addr) : 16'h0000;

  always @(posedge clk) begin
    if (ext_ale) mux_lo <= ext_data_o;
    if (wr_act) begin
      wr_seen_addr <= dev_addr;
      wr_seen_data <= ext_data_o;
    end
  end

  exbus_ctrl #(.NCS(NCS)) u_dut (
    .clk(clk), .rst(rst), .cfg_flat(cfg_flat),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ext_cs_n(ext_cs_n),
    .ext_addr(ext_addr), .ext_be_n(ext_be_n), .ext_data_o(ext_data_o),
    .ext_data_oe(ext_data_oe), .ext_data_i(ext_data_i), .ext_ale(ext_ale),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_rw(ext_rw), .ext_ds_n(ext_ds_n)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    bit          err;
    bit          rd;
    logic [15:0] data;
  } exp_t;
  exp_t sb_q[$];

  always @(negedge clk) begin : monitor
    exp_t e;
    if (!rst && req_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11", "ready without request", 1, 0);
      end else begin
        e = sb_q.pop_front();
        check(rsp_err == e.err, "R2", "error flag", int'(rsp_err), int'(e.err));
        if (e.rd) check(rsp_rdata == e.data, "R10", "read data", int'(rsp_rdata), int'(e.data));
      end
    end
  end

  task automatic do_acc(bit wr, logic [23:0] a, logic [15:0] d, logic [1:0] be);
    int c, cc, lat, n, ncs, nstb, first_stb, nale, obs;
    int bad_cs, bad_rw, bad_stb, bad_wd, bad_ale, bad_oe;
    bit stb;
    exp_t e;
    c  = exp_cs(a);
    cc = (c < 0) ? 0 : c;
    lat = 1;
    if (c >= 0) lat = tp[c][0] + tp[c][1] + tp[c][2] + tp[c][3] + tp[c][4] + 6;
    cur_mux = (c >= 0) && (b_mux[cc] != 0);
    e.err  = (c < 0);
    e.rd   = !wr && (c >= 0);
    e.data = dev_fn(a);
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    n = 0; ncs = 0; nstb = 0; first_stb = 0; nale = 0; obs = -1;
    bad_cs = 0; bad_rw = 0; bad_stb = 0; bad_wd = 0; bad_ale = 0; bad_oe = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (ext_cs_n != '1) begin
        ncs++;
        for (int k = 0; k < NCS; k++) if (!ext_cs_n[k]) obs = k;
        if (c < 0 || ext_cs_n != ~(8'd1 << cc)) bad_cs++;
        if (ext_addr != a || ext_be_n != ~be) bad_cs++;
        if (ext_rw != !(b_moto[cc] != 0 && wr)) bad_rw++;
      end
      if (b_moto[cc] != 0) stb = !ext_ds_n;
      else                 stb = wr ? !ext_wr_n : !ext_rd_n;
      if ((!ext_rd_n || !ext_wr_n || !ext_ds_n) && !stb) bad_stb++;
      if (stb) begin
        nstb++;
        if (first_stb == 0) first_stb = n;
        if (wr && !(ext_data_oe && ext_data_o == d)) bad_wd++;
      end
      if (ext_ale) begin
        nale++;
        if (!(ext_data_oe && ext_data_o == a[15:0])) bad_ale++;
      end
      if (!ext_ale && !stb && ext_data_oe) bad_oe++;
      if (req_ready || n > 300) break;
    end
    if (c < 0) begin
      check(n == 1, "R2", "miss completion cycle", n, 1);
      check(ncs == 0 && nstb == 0, "R2", "bus activity on miss", ncs + nstb, 0);
    end else begin
      check(n == lat, "R4", "ready cycle", n, lat);
      check(nstb == tp[c][2] + 1, "R4", "strobe length", nstb, tp[c][2] + 1);
      check(first_stb == tp[c][0] + tp[c][1] + 3, "R4", "strobe start", first_stb,
            tp[c][0] + tp[c][1] + 3);
      check(obs == c, "R3", "serving chip select", obs, c);
      check(ncs == tp[c][0] + tp[c][1] + tp[c][2] + tp[c][3] + 4 && bad_cs == 0, "R5",
            "chip select span", ncs, tp[c][0] + tp[c][1] + tp[c][2] + tp[c][3] + 4);
      if (b_moto[c] != 0) begin
        check(bad_stb == 0, "R7", "foreign strobe", bad_stb, 0);
        check(bad_rw == 0, "R7", "rw level", bad_rw, 0);
      end else begin
        check(bad_stb == 0 && bad_rw == 0, "R6", "strobe pins", bad_stb + bad_rw, 0);
      end
      check(nale == ((b_mux[c] != 0) ? tp[c][0] + 1 : 0) && bad_ale == 0, "R8",
            "address latch phase", nale, (b_mux[c] != 0) ? tp[c][0] + 1 : 0);
      check(bad_oe == 0 && bad_wd == 0, "R9", "data drive", bad_oe + bad_wd, 0);
      if (wr) check(wr_seen_data == d && wr_seen_addr == a, "R9", "device write",
                    int'(wr_seen_data), int'(d));
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready && ext_cs_n == '1, "R11", "ready single cycle", int'(req_ready), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NCS; i++) begin
      b_en[i] = 0; b_moto[i] = 0; b_mux[i] = 0; b_size[i] = 0; b_base[i] = 0;
      for (int p = 0; p < 5; p++) tp[i][p] = 0;
    end
    // CS0: separate strobes, separate pins, 512 B at 0
    b_en[0] = 1; b_size[0] = 0; b_base[0] = 'h000000;
    tp[0][0] = 0; tp[0][1] = 1; tp[0][2] = 2; tp[0][3] = 0; tp[0][4] = 1;
    // CS1: R/W style, shared pins, 1 MB at 0x100000
    b_en[1] = 1; b_moto[1] = 1; b_mux[1] = 1; b_size[1] = 11; b_base[1] = 'h100000;
    tp[1][0] = 1; tp[1][1] = 0; tp[1][2] = 0; tp[1][3] = 2; tp[1][4] = 0;
    // CS2: whole space but disabled
    b_en[2] = 0; b_size[2] = 15;
    // CS3: separate strobes, shared pins, 2 MB at 0x400000
    b_en[3] = 1; b_mux[3] = 1; b_size[3] = 12; b_base[3] = 'h400000;
    tp[3][0] = 3; tp[3][1] = 2; tp[3][2] = 1; tp[3][3] = 0; tp[3][4] = 2;
    // CS4: R/W style, separate pins, 4 MB at 0x400000 (overlaps CS3)
    b_en[4] = 1; b_moto[4] = 1; b_size[4] = 13; b_base[4] = 'h400000;
    tp[4][0] = 2; tp[4][1] = 0; tp[4][2] = 3; tp[4][3] = 1; tp[4][4] = 0;
    // CS5: R/W style, separate pins, all counts zero, 8 KB at 0x800000
    b_en[5] = 1; b_moto[5] = 1; b_size[5] = 4; b_base[5] = 'h800000;
    // CS6: longest phases, 512 B at 0xC00000
    b_en[6] = 1; b_size[6] = 0; b_base[6] = 'hC00000;
    for (int p = 0; p < 5; p++) tp[6][p] = 15;
    for (int i = 0; i < NCS; i++) cfg_flat[i*42 +: 42] = pack_cfg(i);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ext_cs_n == '1 && ext_rd_n && ext_wr_n && ext_ds_n && ext_rw, "R12",
          "idle strobes after reset", int'(ext_cs_n), 'hFF);
    check(!ext_ale && !ext_data_oe && !req_ready && !rsp_err, "R12",
          "idle flags after reset", int'({ext_ale, ext_data_oe, req_ready, rsp_err}), 0);

    do_acc(1'b1, 24'h000010, 16'h1234, 2'b11);   // R6 write, CS0
    do_acc(1'b0, 24'h0001FE, 16'h0000, 2'b11);   // R2 top of smallest window
    do_acc(1'b0, 24'h000200, 16'h0000, 2'b11);   // R2 just past CS0
    do_acc(1'b1, 24'h100456, 16'hBEEF, 2'b01);   // R7 R8 shared-pin write
    do_acc(1'b0, 24'h1FFFFE, 16'h0000, 2'b10);   // R10 shared-pin read
    do_acc(1'b0, 24'hF00000, 16'h0000, 2'b11);   // R1 disabled whole-space window
    do_acc(1'b0, 24'h5FFFFE, 16'h0000, 2'b11);   // R3 overlap, CS3 wins
    do_acc(1'b1, 24'h400800, 16'hA5A5, 2'b11);   // R3 overlap write
    do_acc(1'b0, 24'h600000, 16'h0000, 2'b11);   // R3 only CS4 matches
    do_acc(1'b1, 24'h801FFE, 16'h0F0F, 2'b11);   // R4 all counts zero
    do_acc(1'b0, 24'h800002, 16'h0000, 2'b11);   // R10 shortest read
    do_acc(1'b0, 24'h802000, 16'h0000, 2'b11);   // R2 past CS5
    do_acc(1'b0, 24'hC00100, 16'h0000, 2'b11);   // R4 longest phases
    do_acc(1'b1, 24'hC001FE, 16'h7E81, 2'b11);   // R9 long write

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R11", "responses outstanding", sb_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule